// File: doc/BRIEF.md
# Doorbell Inter-Processor Signalling Unit

This unit gives software a way to raise interrupts on one or more processors by writing a register. A write to the trigger register of the shared window carries two things: a bitmap of target processors and a doorbell number. Each targeted processor then has the chosen bit set in its own 32-bit pending register. Each processor also has a 32-bit enable register. The unit drives two summary lines per processor into the neighbouring interrupt controller. The first line covers doorbells 0 to 7, which carry messages between processors. The second covers doorbells 16 to 31, which bus masters ring as message-signalled interrupts.

Software acknowledges a pending bit by writing 0 to it. Writing 1 to a pending bit leaves it unchanged, so writing the complement of the serviced bits acknowledges exactly those bits. A bus master rings doorbell 16+n on all four processors with the data value 0xF00 | (n+16).

The shared window takes writes as a valid/ready stream. `gw_ready` is held high, so the unit never applies back-pressure: every beat with `gw_valid` high is taken in the cycle it is presented. Writes to a processor's own window and the read port are plain control pins.

Top module: `dbl_doorbell_unit`

## Requirements
- R1: A shared-window beat with `gw_offs` = 0x04 sets pending bit `gw_data[4:0]` on every processor c whose bit `gw_data[8+c]` is 1, visible after the next clock edge. Bits [7:5], bits [31:16] and bitmap bits at or above NCPU have no effect.
- R2: A trigger beat leaves the pending register of every processor that its bitmap does not name unchanged.
- R3: A per-processor write with `pc_offs` = 0x08 to processor `pc_cpu` clears each pending bit written as 0 and keeps each bit written as 1. Writing 0 clears every pending bit.
- R4: When a trigger and a pending-register write reach the same bit in the same cycle, the bit ends up set.
- R5: A per-processor write with `pc_offs` = 0x0C replaces that processor's 32-bit enable register.
- R6: The read port returns the pending register of `rd_cpu` when `rd_offs` = 0x08, its enable register when `rd_offs` = 0x0C, and 0 for any other offset. The result is combinational.
- R7: `ipi_irq[c]` is high exactly when bits 7:0 of (pending AND enable) of processor c are not all zero.
- R8: `msg_irq[c]` is high exactly when bits 31:16 of (pending AND enable) of processor c are not all zero.
- R9: Doorbells 8 to 15 are latched in the pending register and read back, but they drive neither summary line.
- R10: After reset, all pending and enable registers are 0 and every summary line is low.
- R11: Shared-window beats at any offset other than 0x04 and per-processor writes at offsets other than 0x08 or 0x0C change no state.
- R12: A beat at offset 0x04 with data 0xF00 | (n+16), for n from 0 to 15, sets pending bit 16+n on processors 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| gw_valid | input | 1 | Shared-window write beat valid |
| gw_ready | output | 1 | Always 1, beat taken when valid |
| gw_offs | input | 8 | Shared-window byte offset |
| gw_data | input | 32 | Shared-window write data |
| pc_wr | input | 1 | Per-processor register write strobe |
| pc_cpu | input | CPU_W | Processor whose window is written |
| pc_offs | input | 8 | Per-processor byte offset |
| pc_data | input | 32 | Per-processor write data |
| rd_cpu | input | CPU_W | Processor whose window is read |
| rd_offs | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data |
| ipi_irq | output | NCPU | Inter-processor summary per processor |
| msg_irq | output | NCPU | Message-signalled summary per processor |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that `gw_valid`, `pc_wr` and their data are stable around the rising edge and never unknown after reset. The bench drives every input on the falling edge from ordinary values, so these assumptions hold. Random stimulus covers all trigger and pending-write patterns, including same-cycle collisions, zero writes and stray offsets, so no legal input is ever withheld to keep an assertion true.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  localparam int DB_W      = 32;
  localparam int DB_IDX_W  = $clog2(DB_W);
  localparam int OFFS_W    = 8;
  localparam int TGT_LSB   = 8;
  localparam int TGT_W     = 8;

  // software-visible offsets
  localparam logic [OFFS_W-1:0] OFFS_TRIG  = 8'h04;
  localparam logic [OFFS_W-1:0] OFFS_CAUSE = 8'h08;
  localparam logic [OFFS_W-1:0] OFFS_MASK  = 8'h0C;

  // doorbell groups feeding the two summary lines
  localparam logic [DB_W-1:0] IPI_GROUP = 32'h0000_00FF;
  localparam logic [DB_W-1:0] MSG_GROUP = 32'hFFFF_0000;

  function automatic logic [DB_W-1:0] db_onehot(input logic [DB_IDX_W-1:0] idx);
    logic [DB_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dbl_trig_dec.sv
module dbl_trig_dec
  import dbl_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       gw_valid,
  input  logic [OFFS_W-1:0]          gw_offs,
  input  logic [DB_W-1:0]            gw_data,
  output logic [NCPU-1:0][DB_W-1:0]  set_vec
);
  logic            hit;
  logic [DB_W-1:0] bit_sel;

  assign hit     = gw_valid && (gw_offs == OFFS_TRIG);
  assign bit_sel = db_onehot(gw_data[DB_IDX_W-1:0]);

  for (genvar c = 0; c < NCPU; c++) begin : g_tgt
    assign set_vec[c] = (hit && gw_data[TGT_LSB + c]) ? bit_sel : '0;

    // R1: a trigger rings at most one doorbell per processor
    a_r1_one_bell: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_vec[c]));
  end
endmodule

// File: rtl/dbl_cpu_bank.sv
module dbl_cpu_bank
  import dbl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DB_W-1:0] set_bits,
  input  logic            cause_we,
  input  logic            mask_we,
  input  logic [DB_W-1:0] wdata,
  output logic [DB_W-1:0] cause_q,
  output logic [DB_W-1:0] mask_q,
  output logic            ipi_irq,
  output logic            msg_irq
);
  logic [DB_W-1:0] kept;
  logic [DB_W-1:0] live;

  // write-zero-to-clear, then OR in new doorbells so a set always wins
  assign kept = cause_we ? (cause_q & wdata) : cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= kept | set_bits;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign live    = cause_q & mask_q;
  assign ipi_irq = |(live & IPI_GROUP);
  assign msg_irq = |(live & MSG_GROUP);

  // R4: every rung doorbell is pending one cycle later
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_bits) & ~cause_q) == '0));

  // R3: no pending bit appears without a trigger
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_bits)) == '0));

  // R3: a zero write with no trigger empties the register
  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_we && wdata == '0 && set_bits == '0) |=> (cause_q == '0));

  // R5: the enable register only changes on its own write
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  // R7, R8, R9: a summary line needs an enabled pending bit of its group
  a_r7_ipi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_irq |-> ((cause_q & mask_q & IPI_GROUP) != '0));
  a_r8_msg_cause: assert property (@(posedge clk) disable iff (!rst_n)
    msg_irq |-> ((cause_q & mask_q & MSG_GROUP) != '0));
endmodule

// File: rtl/dbl_doorbell_unit.sv
module dbl_doorbell_unit
  import dbl_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gw_valid,
  output logic              gw_ready,
  input  logic [OFFS_W-1:0] gw_offs,
  input  logic [DB_W-1:0]   gw_data,
  input  logic              pc_wr,
  input  logic [CPU_W-1:0]  pc_cpu,
  input  logic [OFFS_W-1:0] pc_offs,
  input  logic [DB_W-1:0]   pc_data,
  input  logic [CPU_W-1:0]  rd_cpu,
  input  logic [OFFS_W-1:0] rd_offs,
  output logic [DB_W-1:0]   rd_data,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   msg_irq
);
  logic [NCPU-1:0][DB_W-1:0] set_vec;
  logic [NCPU-1:0][DB_W-1:0] cause_q;
  logic [NCPU-1:0][DB_W-1:0] mask_q;

  assign gw_ready = 1'b1;

  dbl_trig_dec #(.NCPU(NCPU)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .gw_valid (gw_valid),
    .gw_offs  (gw_offs),
    .gw_data  (gw_data),
    .set_vec  (set_vec)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic sel, c_we, m_we;
    assign sel  = pc_wr && (pc_cpu == CPU_W'(c));
    assign c_we = sel && (pc_offs == OFFS_CAUSE);
    assign m_we = sel && (pc_offs == OFFS_MASK);

    dbl_cpu_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (set_vec[c]),
      .cause_we (c_we),
      .mask_we  (m_we),
      .wdata    (pc_data),
      .cause_q  (cause_q[c]),
      .mask_q   (mask_q[c]),
      .ipi_irq  (ipi_irq[c]),
      .msg_irq  (msg_irq[c])
    );

    // R2: an untargeted processor with no own write keeps its pending bits
    a_r2_untargeted: assert property (@(posedge clk) disable iff (!rst_n)
      (gw_valid && gw_offs == OFFS_TRIG && !gw_data[TGT_LSB + c] && !c_we)
        |=> $stable(cause_q[c]));
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (rd_cpu == CPU_W'(c)) begin
        if (rd_offs == OFFS_CAUSE)     rd_data = cause_q[c];
        else if (rd_offs == OFFS_MASK) rd_data = mask_q[c];
      end
    end
  end
endmodule

// File: tb/dbl_doorbell_unit_test.sv
module dbl_doorbell_unit_test;
  localparam int CLK_PERIOD = 20;
  localparam int NCPU = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic gw_valid = 1'b0, pc_wr = 1'b0;
  logic gw_ready;
  logic [7:0] gw_offs = '0, pc_offs = '0, rd_offs = '0;
  logic [31:0] gw_data = '0, pc_data = '0, rd_data;
  logic [1:0] pc_cpu = '0, rd_cpu = '0;
  logic [NCPU-1:0] ipi_irq, msg_irq;

  int unsigned errors = 0, checks = 0;
  bit done = 1'b0;
  logic [31:0] m_cause [NCPU];
  logic [31:0] m_mask  [NCPU];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl_doorbell_unit #(.NCPU(NCPU)) uut (
    .clk(clk), .rst_n(rst_n), .gw_valid(gw_valid), .gw_ready(gw_ready),
    .gw_offs(gw_offs), .gw_data(gw_data), .pc_wr(pc_wr), .pc_cpu(pc_cpu),
    .pc_offs(pc_offs), .pc_data(pc_data), .rd_cpu(rd_cpu), .rd_offs(rd_offs),
    .rd_data(rd_data), .ipi_irq(ipi_irq), .msg_irq(msg_irq)
  );

  function automatic logic [31:0] trig_bits(int c, logic v, logic [7:0] o, logic [31:0] d);
    if (v && o == 8'h04 && d[8+c]) return 32'h1 << d[4:0];
    return '0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < NCPU; c++) begin
      rd_cpu = 2'(c); rd_offs = 8'h08; #1;
      chk({tag, " R3 pending"}, rd_data, m_cause[c]);
      rd_offs = 8'h0C; #1;
      chk({tag, " R5 enable"}, rd_data, m_mask[c]);
      chk({tag, " R7 ipi"}, 32'(ipi_irq[c]), 32'(|(m_cause[c] & m_mask[c] & 32'h0000_00FF)));
      chk({tag, " R8 msg"}, 32'(msg_irq[c]), 32'(|(m_cause[c] & m_mask[c] & 32'hFFFF_0000)));
    end
  endtask

  // drive one cycle, update the model, sample on the falling edge
  task automatic step(logic gv, logic [7:0] go, logic [31:0] gd,
                      logic pw, logic [1:0] pcu, logic [7:0] po, logic [31:0] pd);
    gw_valid = gv; gw_offs = go; gw_data = gd;
    pc_wr = pw; pc_cpu = pcu; pc_offs = po; pc_data = pd;
    @(posedge clk);
    for (int c = 0; c < NCPU; c++) begin
      logic [31:0] k;
      k = m_cause[c];
      if (pw && pcu == 2'(c) && po == 8'h08) k = k & pd;
      m_cause[c] = k | trig_bits(c, gv, go, gd);
      if (pw && pcu == 2'(c) && po == 8'h0C) m_mask[c] = pd;
    end
    @(negedge clk);
    gw_valid = 1'b0; pc_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCPU; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10 reset");
    chk("R10 ipi low", 32'(ipi_irq), 32'h0);
    chk("gw_ready", 32'(gw_ready), 32'h1);

    for (int c = 0; c < NCPU; c++) step(0, 0, 0, 1, 2'(c), 8'h0C, 32'hFFFF_00FF);
    check_all("R5 enable write");
    step(1, 8'h04, 32'h0000_0203, 0, 0, 0, 0);
    check_all("R1 R2 R7 doorbell 3 to cpu1");
    step(1, 8'h04, 32'h0000_0F15, 0, 0, 0, 0);
    check_all("R12 R8 message n=5");
    step(1, 8'h04, 32'hFFFF_F0E7, 0, 0, 0, 0);
    check_all("R1 ignored bitmap bits");
    step(0, 0, 0, 1, 2'd0, 8'h08, 32'h0);
    check_all("R3 zero clears");
    step(0, 0, 0, 1, 2'd1, 8'h08, ~32'h0000_0008);
    check_all("R3 complement acknowledge");
    step(1, 8'h04, 32'h0000_010A, 1, 2'd0, 8'h0C, 32'hFFFF_FFFF);
    check_all("R9 doorbell 10 latched");
    chk("R9 ipi0 low", 32'(ipi_irq[0]), 32'h0);
    step(1, 8'h04, 32'h0000_0415, 1, 2'd2, 8'h08, 32'h0);
    check_all("R4 set wins over clear");
    step(1, 8'h08, 32'h0000_0F02, 1, 2'd3, 8'h10, 32'h0);
    check_all("R11 stray offsets");
    rd_cpu = 2'd3; rd_offs = 8'h04; #1;
    chk("R6 other read offset", rd_data, 32'h0);

    for (int i = 0; i < 1500; i++) begin
      logic [7:0] go, po;
      logic [31:0] gd, pd;
      go = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h04;
      gd = $urandom;
      case ($urandom_range(0, 3))
        0: po = 8'h08;
        1: po = 8'h0C;
        2: po = 8'h08;
        default: po = 8'($urandom);
      endcase
      pd = ($urandom_range(0, 5) == 0) ? 32'h0 : $urandom;
      step(1'($urandom), go, gd, 1'($urandom), 2'($urandom), po, pd);
      check_all("R1 R2 R3 R4 R5 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule